// File: doc/BRIEF.md
# Mixed Edge/Level External Interrupt Unit

This unit takes eight asynchronous interrupt pins and turns each one into a latched source flag and a per-channel interrupt request. Channels 0 to 3 are edge channels. Each has a two-bit edge selector for rising, falling, both edges or none. Channels 4 to 7 are level channels. Each has an inversion bit that picks the active level. Every pin passes through a multi-stage synchroniser and a minimum-width filter before it is evaluated, so pulses that are too short never reach a flag.

A byte-wide register bus sets the edge selectors, level inversions and enables, and gives access to the flags. A wake output tells the power manager that the device should resume. While the clock runs, wake follows any active request. When the power manager raises the stop input and gates the clock, a clock-free path keeps wake working: pin-clocked latches catch selected edges on enabled edge channels, and a combinational term covers enabled level channels at their active level. Vector fetch, priority and oscillator restart are handled elsewhere.

Top module: `xirq_unit`

## Requirements
- R1: After reset, the edge selectors, inversions, enables and edge flags are zero. `irq_o` is zero, `wake_o` is low and `rdata_o` reads zero.
- R2: `rdata_o` shows the addressed register one cycle after the address is presented. The map is: 0 edge select, 1 level inversion in bits 3:0 (bits 7:4 read zero), 2 enable (bit k = channel k), 3 flags (bits 3:0 edge, bits 7:4 level). Addresses 4 to 7 read zero and ignore writes.
- R3: The field for edge channel k is bits 2k+1:2k of register 0. Code 00 never flags, 01 flags rising transitions, 10 flags falling transitions and 11 flags both.
- R4: An edge flag stays set until 0 is written to its bit in register 3. Writing 1 leaves it unchanged. Writes to bits 7:4 of register 3 have no effect on the level flags.
- R5: A level flag is 1 while its filtered input equals the active level and 0 otherwise. Inversion bit 0 means active-high and 1 means active-low.
- R6: `irq_o[k]` is high exactly when flag k and enable bit k are both set. Clearing the enable bit drops the request on the next cycle and leaves the flag unchanged.
- R7: A pin value reaches detection only after the synchronised value has differed from the filtered value for MIN_W consecutive cycles; shorter pulses are dropped. With the defaults (2 stages, MIN_W 2), a flag is set on the fifth rising clock edge after the pin changes.
- R8: `wake_o` is high whenever any bit of `irq_o` is high.
- R9: While `stop_i` is high, with no clock running, a selected edge on an enabled edge channel raises `wake_o`. Lowering `stop_i` clears that latch.
- R10: While `stop_i` is high, an enabled level channel whose pin sits at its active level holds `wake_o` high without a clock.
- R11: If a pin edge occurs while the clock is stopped and the pin keeps its new value, the matching edge flag is set once the clock resumes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, gated off by the power manager in stop |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Asynchronous interrupt pins, bit k = channel k |
| stop_i | input | 1 | High while the clock is, or is about to be, stopped |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| irq_o | output | 8 | Per-channel interrupt request |
| wake_o | output | 1 | Resume request to the power manager |

## Verification
The clocked properties assume a reset that is held across at least one edge. They also assume that flags and enables change only through the bus or through detected pin activity. They say nothing about the clock-free stop path, because no edge occurs while the clock is gated. The stimulus therefore drives pins half a cycle away from the clock. It raises `stop_i` before gating the clock low and restores the clock only in its low phase, so the gated clock never glitches. The wake behaviour in stop is checked directly against time delays rather than clock edges.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int NUM_EDGE = 4;
  localparam int NUM_LVL  = 4;
  localparam int NUM_CH   = NUM_EDGE + NUM_LVL;
  localparam int BUS_W    = 8;
  localparam int ADDR_W   = 3;
  localparam int SEL_W    = 2 * NUM_EDGE;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  localparam logic [ADDR_W-1:0] A_EDGE_SEL = 3'd0;
  localparam logic [ADDR_W-1:0] A_LVL_INV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_ENABLE   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FLAGS    = 3'd3;
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  generate
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= '0;
        else     stg[s] <= stg[s-1];
      end
    end
  endgenerate

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/xirq_filter.sv
module xirq_filter #(
  parameter int W     = 8,
  parameter int MIN_W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] clean_o
);
  localparam int CW = (MIN_W > 1) ? $clog2(MIN_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(MIN_W - 1);

  generate
    for (genvar k = 0; k < W; k++) begin : g_ch
      logic [CW-1:0] run;
      logic          held;
      always_ff @(posedge clk) begin
        if (rst) begin
          run  <= '0;
          held <= 1'b0;
        end else if (raw_i[k] == held) begin
          run <= '0;
        end else if (run == LAST) begin
          held <= raw_i[k];
          run  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end
      assign clean_o[k] = held;
    end
  endgenerate
endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int NE = NUM_EDGE,
  parameter int NL = NUM_LVL
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NE+NL-1:0] clean_i,
  input  logic [2*NE-1:0]  sel_i,
  input  logic [NL-1:0]    inv_i,
  output logic [NE-1:0]    edge_hit_o,
  output logic [NL-1:0]    lvl_act_o
);
  logic [NE-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= clean_i[NE-1:0];
  end

  generate
    for (genvar k = 0; k < NE; k++) begin : g_edge
      logic      rise, fall;
      edge_sel_e mode;
      assign rise = clean_i[k] & ~prev[k];
      assign fall = ~clean_i[k] & prev[k];
      assign mode = edge_sel_e'(sel_i[2*k +: 2]);
      always_comb begin
        case (mode)
          EDGE_RISE: edge_hit_o[k] = rise;
          EDGE_FALL: edge_hit_o[k] = fall;
          EDGE_BOTH: edge_hit_o[k] = rise | fall;
          default:   edge_hit_o[k] = 1'b0;
        endcase
      end
    end
  endgenerate

  assign lvl_act_o = clean_i[NE +: NL] ^ inv_i;
endmodule

// File: rtl/xirq_stop_latch.sv
module xirq_stop_latch #(
  parameter int NE = 4,
  parameter int NL = 4
) (
  input  logic             stop_i,
  input  logic [NE+NL-1:0] pin_i,
  input  logic [2*NE-1:0]  sel_i,
  input  logic [NL-1:0]    inv_i,
  input  logic [NE+NL-1:0] en_i,
  output logic             wake_o
);
  logic [NE-1:0] edge_wake;
  logic [NL-1:0] lvl_wake;

  generate
    for (genvar k = 0; k < NE; k++) begin : g_edge
      logic arm_r, arm_f, hit_r, hit_f;
      assign arm_r = stop_i & en_i[k] & sel_i[2*k];
      assign arm_f = stop_i & en_i[k] & sel_i[2*k+1];

      always_ff @(posedge pin_i[k] or negedge arm_r) begin
        if (!arm_r) hit_r <= 1'b0;
        else        hit_r <= 1'b1;
      end

      always_ff @(negedge pin_i[k] or negedge arm_f) begin
        if (!arm_f) hit_f <= 1'b0;
        else        hit_f <= 1'b1;
      end

      assign edge_wake[k] = hit_r | hit_f;
    end
  endgenerate

  assign lvl_wake = {NL{stop_i}} & en_i[NE +: NL] & (pin_i[NE +: NL] ^ inv_i);
  assign wake_o   = (|edge_wake) | (|lvl_wake);
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  input  logic [NUM_EDGE-1:0] edge_hit_i,
  input  logic [NUM_LVL-1:0]  lvl_act_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [NUM_LVL-1:0] inv_o,
  output logic [NUM_CH-1:0] en_o,
  output logic [NUM_CH-1:0] flag_o
);
  logic [NUM_EDGE-1:0] edge_flag;
  logic [NUM_LVL-1:0]  lvl_flag;
  logic [NUM_EDGE-1:0] clr;
  logic [BUS_W-1:0]    rd_mux;

  assign clr = (wr_i && addr_i == A_FLAGS) ? ~wdata_i[NUM_EDGE-1:0] : '0;

  always_comb begin
    case (addr_i)
      A_EDGE_SEL: rd_mux = BUS_W'(sel_o);
      A_LVL_INV:  rd_mux = BUS_W'(inv_o);
      A_ENABLE:   rd_mux = BUS_W'(en_o);
      A_FLAGS:    rd_mux = BUS_W'({lvl_flag, edge_flag});
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_o     <= '0;
      inv_o     <= '0;
      en_o      <= '0;
      edge_flag <= '0;
      lvl_flag  <= '0;
      rdata_o   <= '0;
    end else begin
      if (wr_i) begin
        case (addr_i)
          A_EDGE_SEL: sel_o <= wdata_i[SEL_W-1:0];
          A_LVL_INV:  inv_o <= wdata_i[NUM_LVL-1:0];
          A_ENABLE:   en_o  <= wdata_i[NUM_CH-1:0];
          default: ;
        endcase
      end
      edge_flag <= (edge_flag & ~clr) | edge_hit_i;
      lvl_flag  <= lvl_act_i;
      rdata_o   <= rd_mux;
    end
  end

  assign flag_o = {lvl_flag, edge_flag};
endmodule

// File: rtl/xirq_unit.sv
module xirq_unit
  import xirq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_W       = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] pin_i,
  input  logic              stop_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic [NUM_CH-1:0] irq_o,
  output logic              wake_o
);
  logic [NUM_CH-1:0]   synced, clean, en, flag;
  logic [SEL_W-1:0]    sel;
  logic [NUM_LVL-1:0]  inv, lvl_act;
  logic [NUM_EDGE-1:0] edge_hit;
  logic                stop_wake;

  xirq_sync #(.W(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d_i(pin_i), .q_o(synced)
  );

  xirq_filter #(.W(NUM_CH), .MIN_W(MIN_W)) u_filt (
    .clk(clk), .rst(rst), .raw_i(synced), .clean_o(clean)
  );

  xirq_detect #(.NE(NUM_EDGE), .NL(NUM_LVL)) u_det (
    .clk(clk), .rst(rst), .clean_i(clean), .sel_i(sel), .inv_i(inv),
    .edge_hit_o(edge_hit), .lvl_act_o(lvl_act)
  );

  xirq_regs u_regs (
    .clk(clk), .rst(rst), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
    .edge_hit_i(edge_hit), .lvl_act_i(lvl_act), .rdata_o(rdata_o),
    .sel_o(sel), .inv_o(inv), .en_o(en), .flag_o(flag)
  );

  xirq_stop_latch #(.NE(NUM_EDGE), .NL(NUM_LVL)) u_stop (
    .stop_i(stop_i), .pin_i(pin_i), .sel_i(sel), .inv_i(inv), .en_i(en),
    .wake_o(stop_wake)
  );

  assign irq_o  = flag & en;
  assign wake_o = (|irq_o) | stop_wake;
endmodule

// File: rtl/xirq_unit_chk.sv
module xirq_unit_chk
  import xirq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  wdata_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic [NUM_CH-1:0] irq_o,
  input logic              wake_o
);
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $fell(rst) |-> (irq_o == '0));

  a_r2_unused_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr_i >= 3'd4) |=> (rdata_o == '0));

  a_r8_wake_covers_irq: assert property (@(posedge clk) disable iff (rst)
    (irq_o != '0) |-> wake_o);

  generate
    for (genvar k = 0; k < NUM_EDGE; k++) begin : g_edge
      a_r4_edge_request_holds: assert property (@(posedge clk) disable iff (rst)
        (irq_o[k] && !(wr_i && (addr_i == A_FLAGS || addr_i == A_ENABLE)))
        |=> irq_o[k]);
    end
    for (genvar k = 0; k < NUM_CH; k++) begin : g_all
      a_r6_disable_drops: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == A_ENABLE && !wdata_i[k]) |=> !irq_o[k]);
    end
  endgenerate
endmodule

bind xirq_unit xirq_unit_chk u_chk (
  .clk(clk), .rst(rst), .wr_i(wr_i), .addr_i(addr_i), .wdata_i(wdata_i),
  .rdata_o(rdata_o), .irq_o(irq_o), .wake_o(wake_o)
);

// File: tb/sim_xirq_unit.sv
`timescale 1ns/1ps
module sim_xirq_unit;
  typedef struct {
    int         kind;   // 0 read data, 1 irq, 2 wake
    logic [7:0] exp;
    int         issue;
    string      req;
  } item_t;

  logic       clk_raw = 1'b0;
  logic       clk_en  = 1'b1;
  logic       clk;
  logic       rst = 1'b1;
  logic [7:0] pin = '0;
  logic       stop = 1'b0;
  logic       wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, irq;
  logic       wake;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  bit    done = 1'b0;
  item_t q[$];

  always #2 clk_raw = ~clk_raw;
  assign clk = clk_raw & clk_en;
  always @(posedge clk) cyc <= cyc + 1;

  xirq_unit u0 (
    .clk(clk), .rst(rst), .pin_i(pin), .stop_i(stop), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .wake_o(wake)
  );

  // monitor: pops expected items once the design has produced them
  initial forever begin
    @(negedge clk);
    while (q.size() > 0 &&
           ((q[0].kind == 0) ? (cyc > q[0].issue) : (cyc >= q[0].issue))) begin
      item_t      it;
      logic [7:0] act;
      it = q.pop_front();
      case (it.kind)
        0:       act = rdata;
        1:       act = irq;
        default: act = {7'b0, wake};
      endcase
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", it.req, act, it.exp);
      end
    end
  end

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    addr = a; wdata = d; wr = 1'b1;
    tick(1);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string r);
    item_t it;
    addr = a;
    it.kind = 0; it.exp = e; it.issue = cyc; it.req = r;
    q.push_back(it);
    tick(1);
  endtask

  task automatic port(input int k, input logic [7:0] e, input string r);
    item_t it;
    it.kind = k; it.exp = e; it.issue = cyc; it.req = r;
    q.push_back(it);
  endtask

  task automatic direct(input logic a, input logic e, input string r);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b", r, a, e);
    end
  endtask

  task automatic halt_clock();
    tick(2);
    stop = 1'b1;
    @(negedge clk); #1;
    clk_en = 1'b0;
    #10;
  endtask

  task automatic resume_clock();
    stop = 1'b0;
    #3;
    @(negedge clk_raw); #1;
    clk_en = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, 8'h00, "R1 edge select");
    rd(3'd1, 8'h00, "R1 inversion");
    rd(3'd2, 8'h00, "R1 enable");
    rd(3'd3, 8'h00, "R1 flags");
    port(1, 8'h00, "R1 irq");
    port(2, 8'h00, "R1 wake");

    // R2 register map
    wreg(3'd0, 8'hE4); rd(3'd0, 8'hE4, "R2 edge select");
    wreg(3'd1, 8'hA5); rd(3'd1, 8'h05, "R2 inversion upper bits");
    wreg(3'd1, 8'h00);
    wreg(3'd2, 8'hFF); rd(3'd2, 8'hFF, "R2 enable");
    wreg(3'd6, 8'h33); rd(3'd6, 8'h00, "R2 unused address");
    rd(3'd5, 8'h00, "R2 unused address");
    wreg(3'd2, 8'h0F);

    // R3 edge codes: ch0 off, ch1 rise, ch2 fall, ch3 both
    pin[3:0] = 4'hF; tick(8);
    rd(3'd3, 8'h0A, "R3 rising");
    port(1, 8'h0A, "R6 irq after rise");
    wreg(3'd3, 8'h00); rd(3'd3, 8'h00, "R4 clear by zero");
    pin[3:0] = 4'h0; tick(8);
    rd(3'd3, 8'h0C, "R3 falling");
    port(1, 8'h0C, "R6 irq after fall");

    // R4 write-one keeps, write-zero clears one bit
    wreg(3'd3, 8'hFF); rd(3'd3, 8'h0C, "R4 write one keeps");
    wreg(3'd3, 8'hF7); rd(3'd3, 8'h04, "R4 single clear");

    // R6 / R8 enable gating and wake
    wreg(3'd2, 8'h00);
    port(1, 8'h00, "R6 disabled");
    port(2, 8'h00, "R8 wake idle");
    rd(3'd3, 8'h04, "R6 flag kept");
    wreg(3'd2, 8'h0F);
    port(1, 8'h04, "R6 re-enabled");
    port(2, 8'h01, "R8 wake follows irq");
    wreg(3'd3, 8'h00);

    // R5 level channels
    wreg(3'd2, 8'hF0);
    pin[4] = 1'b1; tick(8);
    rd(3'd3, 8'h10, "R5 active high");
    port(1, 8'h10, "R5 level irq");
    pin[4] = 1'b0; tick(8);
    rd(3'd3, 8'h00, "R5 level released");
    wreg(3'd1, 8'h02); tick(2);
    rd(3'd3, 8'h20, "R5 active low");
    wreg(3'd3, 8'h00); rd(3'd3, 8'h20, "R4 level bits ignore writes");
    wreg(3'd1, 8'h00); tick(2);
    rd(3'd3, 8'h00, "R5 inversion restored");

    // R7 minimum width and latency
    wreg(3'd0, 8'h55); wreg(3'd2, 8'h0F); wreg(3'd3, 8'h00);
    pin[0] = 1'b1; tick(1); pin[0] = 1'b0; tick(8);
    rd(3'd3, 8'h00, "R7 short pulse dropped");
    pin[1] = 1'b1; tick(2); pin[1] = 1'b0; tick(8);
    rd(3'd3, 8'h02, "R7 minimum pulse kept");
    wreg(3'd3, 8'h00);
    pin[2] = 1'b1; tick(4);
    port(1, 8'h00, "R7 not before fifth edge");
    tick(1);
    port(1, 8'h04, "R7 on fifth edge");
    wreg(3'd3, 8'h00);

    // R9 / R11 edge wake in stop
    wreg(3'd2, 8'h00);
    pin[2] = 1'b0; tick(8);
    wreg(3'd0, 8'h06);
    pin[0] = 1'b1; tick(8);
    wreg(3'd3, 8'h00); wreg(3'd2, 8'h03); tick(2);
    port(1, 8'h00, "R9 quiet before stop");
    halt_clock();
    direct(wake, 1'b0, "R9 no edge yet");
    pin[1] = 1'b1; #3;
    direct(wake, 1'b1, "R9 rising edge wakes");
    stop = 1'b0; #3;
    direct(wake, 1'b0, "R9 latch cleared");
    stop = 1'b1; #3;
    direct(wake, 1'b0, "R9 re-armed quiet");
    pin[0] = 1'b0; #3;
    direct(wake, 1'b1, "R9 falling edge wakes");
    resume_clock();
    tick(8);
    rd(3'd3, 8'h03, "R11 flags after resume");
    port(1, 8'h03, "R11 irq after resume");

    // R10 level wake in stop
    wreg(3'd3, 8'h00); wreg(3'd2, 8'h10); wreg(3'd1, 8'h00); tick(2);
    halt_clock();
    direct(wake, 1'b0, "R10 inactive level");
    pin[4] = 1'b1; #3;
    direct(wake, 1'b1, "R10 active level wakes");
    pin[4] = 1'b0; #3;
    direct(wake, 1'b0, "R10 level released");
    resume_clock();
    tick(4);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk_raw);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule